// File: doc/BRIEF.md
# USB Host Frame and Interrupt Control

This block is the command, status and interrupt core of a USB 1.1 host controller. Software reaches it through a word-wide register port. Through that port it starts and stops the controller, resets it, sets a base address for the frame list, and acknowledges interrupts. While the controller runs, a clock divider marks one frame every `FRAME_CYCLES` clocks, which is nominally 1 ms. At each frame boundary the block advances an 11-bit frame number. It also presents the address of the frame list entry that the schedule fetcher reads next.

The schedule engine reports transfer completions and short packets as single-cycle events. These events are held until the frame ends. At the next boundary they move into a hidden two-bit cause register and raise the USB-interrupt status bit. Because the cause register has two bits, software can enable completion interrupts and short-packet interrupts separately. Error, resume and system-level events set their status bits at once. A level interrupt output combines every status source with its enable.

Register word addresses: 0 command, 1 status, 2 interrupt enable, 3 frame number, 4 frame list base. Read data appears on `reg_rdata` one clock after `reg_rd`.

Top module: `usbh_frame_ctl`

## Requirements
- R1: After reset, the registers read as follows: command 0, status 0x20 (halted only), enable 0, frame number 0. `irq` and `frame_start` are low.
- R2: When a command write changes bit 0 (run) from 0 to 1, status bit 5 (halted) clears. A frame boundary occurs on the next clock, with a `frame_start` pulse and a frame-number increment. Boundaries then follow every `FRAME_CYCLES` clocks.
- R3: A command write with bit 0 clear sets halted at once. At the next boundary the divider stops, and no further `frame_start` pulse or frame-number change follows.
- R4: A frame-number write keeps only bits 10:0 and takes effect only while halted. The frame number wraps from 0x7FF to 0.
- R5: The base register discards bits 11:0. `frame_addr` equals the base plus four times frame-number bits 9:0.
- R6: Completion (`evt_done`) and short-packet (`evt_short`) events are held during the frame. At the next boundary they are ORed into cause bits 0 and 1, and status bit 0 is set.
- R7: `irq` is asserted in each of these cases: cause bit 0 is set with enable bit 2; cause bit 1 is set with enable bit 3; status bit 1 (USB error, set by `evt_err`) is set with enable bit 0; status bit 2 (resume detect) is set with enable bit 1.
- R8: Status bit 3 (system error, set by `evt_hse`) and status bit 4 (process error, set by `evt_perr`) assert `irq` whatever the enables hold.
- R9: Writing 1 to a status bit in 4:0 clears that bit. Writing 1 to bit 0 also clears both cause bits.
- R10: `evt_resume` with command bit 3 (suspend enable) set sets command bit 4 (force resume) and status bit 2. With bit 3 clear, it has no effect.
- R11: Writing command bit 1 (host reset) clears command, enable, frame number and pending causes, and returns status to 0x20. The bit clears itself one clock later, and the frame divider stops.
- R12: `bus_reset` follows command bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one clock after reg_rd |
| evt_done | input | 1 | Transfer completion requesting an interrupt |
| evt_short | input | 1 | Short packet requesting an interrupt |
| evt_err | input | 1 | USB transaction error |
| evt_hse | input | 1 | Host system error |
| evt_perr | input | 1 | Schedule process error |
| evt_resume | input | 1 | Resume signalling seen on the bus |
| irq | output | 1 | Level interrupt request |
| frame_start | output | 1 | One-clock pulse at each frame boundary |
| frame_addr | output | 32 | Address of the current frame list entry |
| bus_reset | output | 1 | Global bus reset request |

## Verification
A corrupted divider count or run flag shows within one frame: `frame_start` appears early, late or not at all, and the frame-number reads and `frame_addr` drift from the count the bench keeps. A pending-cause register that loses or leaks an event shows at the first boundary after the event. There `irq` either fails to rise or rises against an enable that should mask it. A cause that survives acknowledgement keeps `irq` high two clocks after the status write. A host reset that misses a register shows in the first read-back afterwards.

// File: rtl/usbh_fc_pkg.sv
package usbh_fc_pkg;
  localparam int CMD_W = 5;
  localparam int ST_W  = 6;
  localparam int IEN_W = 4;
  localparam int CAUSE_W = 2;

  typedef enum logic [2:0] {
    RA_CMD  = 3'd0,
    RA_STS  = 3'd1,
    RA_IEN  = 3'd2,
    RA_FNUM = 3'd3,
    RA_BASE = 3'd4
  } reg_addr_e;

  localparam int CMD_RUN   = 0;
  localparam int CMD_HCRST = 1;
  localparam int CMD_GRST  = 2;
  localparam int CMD_SUSP  = 3;
  localparam int CMD_FGR   = 4;

  localparam int ST_INT  = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_RD   = 2;
  localparam int ST_HSE  = 3;
  localparam int ST_PERR = 4;
  localparam int ST_HALT = 5;

  localparam int IE_ERR   = 0;
  localparam int IE_RD    = 1;
  localparam int IE_DONE  = 2;
  localparam int IE_SHORT = 3;
endpackage

// File: rtl/usbh_frame_timer.sv
module usbh_frame_timer #(
  parameter int FRAME_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic stop,
  output logic tick
);
  localparam int CW = (FRAME_CYCLES > 2) ? $clog2(FRAME_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(FRAME_CYCLES - 1);

  logic          ticking;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || stop) begin
      ticking <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      ticking <= 1'b1;
      cnt     <= LAST;
    end else if (ticking) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign tick = ticking && (cnt == LAST);

  // R3: a stop request at a boundary ends the tick stream
  assert_tick_stops_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && stop) |=> !ticking);
endmodule

// File: rtl/usbh_irq_gen.sv
module usbh_irq_gen import usbh_fc_pkg::*; (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               evt_done,
  input  logic               evt_short,
  input  logic               boundary,
  input  logic               ack,
  input  logic [IEN_W-1:0]   ien,
  input  logic               st_err,
  input  logic               st_rd,
  input  logic               st_hse,
  input  logic               st_perr,
  output logic               post,
  output logic               irq
);
  logic [CAUSE_W-1:0] pend;
  logic [CAUSE_W-1:0] cause;
  logic [CAUSE_W-1:0] evts;

  assign evts = {evt_short, evt_done};
  assign post = boundary && (pend != '0);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pend  <= '0;
      cause <= '0;
    end else begin
      pend  <= boundary ? evts : (pend | evts);
      cause <= (ack ? '0 : cause) | (boundary ? pend : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else irq <= (cause[0] && ien[IE_DONE]) || (cause[1] && ien[IE_SHORT]) ||
                (st_err && ien[IE_ERR]) || (st_rd && ien[IE_RD]) ||
                st_hse || st_perr;
  end

  // R9: acknowledge empties the cause register
  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (ack && !boundary) |=> (cause == '0));
  // R8: system-level errors always interrupt
  assert_hse_irq_R8: assert property (@(posedge clk) disable iff (rst)
    (st_hse || st_perr) |=> irq);
endmodule

// File: rtl/usbh_frame_ctl.sv
module usbh_frame_ctl import usbh_fc_pkg::*; #(
  parameter int FRAME_CYCLES = 250000,
  parameter int DW    = 32,
  parameter int FN_W  = 11,
  parameter int IDX_W = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          evt_done,
  input  logic          evt_short,
  input  logic          evt_err,
  input  logic          evt_hse,
  input  logic          evt_perr,
  input  logic          evt_resume,
  output logic          irq,
  output logic          frame_start,
  output logic [DW-1:0] frame_addr,
  output logic          bus_reset
);
  localparam int BASE_LSB = IDX_W + 2;
  localparam int BASE_W   = DW - BASE_LSB;
  localparam logic [ST_W-1:0] ST_RESET = ST_W'(1) << ST_HALT;

  logic [CMD_W-1:0]  cmd;
  logic [ST_W-1:0]   sts, sts_nxt;
  logic [IEN_W-1:0]  ien;
  logic [FN_W-1:0]   fnum;
  logic [BASE_W-1:0] base;
  logic wr_cmd, wr_sts, wr_ien, wr_fnum, wr_base;
  logic hcr, run_rise, tick, adv, post, ack, resume_hit;
  logic wdata_unused;

  assign wdata_unused = ^reg_wdata;
  assign wr_cmd  = reg_wr && (reg_addr == RA_CMD);
  assign wr_sts  = reg_wr && (reg_addr == RA_STS);
  assign wr_ien  = reg_wr && (reg_addr == RA_IEN);
  assign wr_fnum = reg_wr && (reg_addr == RA_FNUM);
  assign wr_base = reg_wr && (reg_addr == RA_BASE);

  assign hcr        = cmd[CMD_HCRST];
  assign run_rise   = wr_cmd && reg_wdata[CMD_RUN] && !cmd[CMD_RUN];
  assign adv        = tick && cmd[CMD_RUN];
  assign ack        = wr_sts && reg_wdata[ST_INT];
  assign resume_hit = evt_resume && cmd[CMD_SUSP];

  usbh_frame_timer #(.FRAME_CYCLES(FRAME_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (run_rise && !hcr),
    .stop  (hcr || (tick && !cmd[CMD_RUN])),
    .tick  (tick)
  );

  usbh_irq_gen u_irq (
    .clk       (clk),
    .rst       (rst),
    .clr       (hcr),
    .evt_done  (evt_done),
    .evt_short (evt_short),
    .boundary  (adv),
    .ack       (ack),
    .ien       (ien),
    .st_err    (sts[ST_ERR]),
    .st_rd     (sts[ST_RD]),
    .st_hse    (sts[ST_HSE]),
    .st_perr   (sts[ST_PERR]),
    .post      (post),
    .irq       (irq)
  );

  // command register: host reset takes effect the clock after it is written
  always_ff @(posedge clk) begin
    if (rst || hcr) cmd <= '0;
    else begin
      if (wr_cmd) cmd <= reg_wdata[CMD_W-1:0];
      if (resume_hit) cmd[CMD_FGR] <= 1'b1;
    end
  end

  always_comb begin
    sts_nxt = sts;
    if (wr_sts) sts_nxt[ST_PERR:0] = sts[ST_PERR:0] & ~reg_wdata[ST_PERR:0];
    if (post)       sts_nxt[ST_INT]  = 1'b1;
    if (evt_err)    sts_nxt[ST_ERR]  = 1'b1;
    if (resume_hit) sts_nxt[ST_RD]   = 1'b1;
    if (evt_hse)    sts_nxt[ST_HSE]  = 1'b1;
    if (evt_perr)   sts_nxt[ST_PERR] = 1'b1;
    if (wr_cmd)     sts_nxt[ST_HALT] = !reg_wdata[CMD_RUN];
    if (tick && !cmd[CMD_RUN]) sts_nxt[ST_HALT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || hcr) begin
      sts  <= ST_RESET;
      ien  <= '0;
      fnum <= '0;
    end else begin
      sts <= sts_nxt;
      if (wr_ien) ien <= reg_wdata[IEN_W-1:0];
      if (adv) fnum <= fnum + 1'b1;
      else if (wr_fnum && sts[ST_HALT]) fnum <= reg_wdata[FN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base        <= '0;
      frame_start <= 1'b0;
    end else begin
      if (wr_base) base <= reg_wdata[DW-1:BASE_LSB];
      frame_start <= adv;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        RA_CMD:  reg_rdata <= DW'(cmd);
        RA_STS:  reg_rdata <= DW'(sts);
        RA_IEN:  reg_rdata <= DW'(ien);
        RA_FNUM: reg_rdata <= DW'(fnum);
        RA_BASE: reg_rdata <= {base, {BASE_LSB{1'b0}}};
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign frame_addr = {base, fnum[IDX_W-1:0], 2'b00};
  assign bus_reset  = cmd[CMD_GRST];

  // R3: stopping sets halted on the next clock
  assert_halt_on_stop_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && !reg_wdata[CMD_RUN] && !hcr) |=> sts[ST_HALT]);
  // R2: every running boundary steps the frame number by one
  assert_fnum_step_R2: assert property (@(posedge clk) disable iff (rst)
    (adv && !hcr) |=> (fnum == FN_W'($past(fnum) + 1'b1)));
  // R4: frame number cannot be written while running
  assert_fnum_locked_R4: assert property (@(posedge clk) disable iff (rst)
    (!sts[ST_HALT] && !adv && !hcr) |=> $stable(fnum));
  // R10: resume under suspend enable
  assert_resume_R10: assert property (@(posedge clk) disable iff (rst)
    (resume_hit && !hcr) |=> (cmd[CMD_FGR] && sts[ST_RD]));
  // R11: host reset clears registers and itself
  assert_hcr_clear_R11: assert property (@(posedge clk) disable iff (rst)
    hcr |=> ((cmd == '0) && (fnum == '0) && (ien == '0) && (sts == ST_RESET)));
endmodule

// File: tb/usbh_frame_ctl_bench.sv
module usbh_frame_ctl_bench;
  localparam int FC = 16;
  localparam int WD = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic evt_done = 0, evt_short = 0, evt_err = 0, evt_hse = 0, evt_perr = 0, evt_resume = 0;
  logic irq, frame_start, bus_reset;
  logic [31:0] frame_addr;

  int vectors = 0;
  int miscompares = 0;

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t sbq[$];

  always #2 clk = ~clk;

  usbh_frame_ctl #(.FRAME_CYCLES(FC)) u_usbh_frame_ctl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_done(evt_done),
    .evt_short(evt_short), .evt_err(evt_err), .evt_hse(evt_hse), .evt_perr(evt_perr),
    .evt_resume(evt_resume), .irq(irq), .frame_start(frame_start),
    .frame_addr(frame_addr), .bus_reset(bus_reset)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // driver: issue a read and push the expected value to the scoreboard
  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    exp_t item;
    item.exp = e; item.tag = tag;
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    sbq.push_back(item);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // monitor: compare read data one clock after the strobe
  initial begin
    exp_t got;
    forever begin
      @(posedge clk);
      if (reg_rd) begin
        @(negedge clk);
        got = sbq.pop_front();
        check(got.tag, reg_rdata, got.exp);
      end
    end
  end

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: evt_done = 1'b1;
      1: evt_short = 1'b1;
      2: evt_err = 1'b1;
      3: evt_hse = 1'b1;
      4: evt_perr = 1'b1;
      default: evt_resume = 1'b1;
    endcase
    @(negedge clk);
    {evt_done, evt_short, evt_err, evt_hse, evt_perr, evt_resume} = '0;
  endtask

  task automatic settle(); repeat (2) @(negedge clk); endtask

  task automatic wait_frame();
    do @(negedge clk); while (!frame_start);
  endtask

  task automatic count_frames(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (frame_start) cnt++;
    end
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    miscompares++; vectors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] addr_snap;
    int nf;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rd(3'd0, 32'h0, "R1 cmd");
    rd(3'd1, 32'h20, "R1 sts");
    rd(3'd2, 32'h0, "R1 ien");
    rd(3'd3, 32'h0, "R1 fnum");
    check("R1 irq", irq, 0);
    check("R1 frame_start", frame_start, 0);

    // R5 base alignment
    wr(3'd4, 32'h1234_5FFF);
    rd(3'd4, 32'h1234_5000, "R5 base");
    check("R5 frame_addr idle", frame_addr, 32'h1234_5000);

    // R2 run start: immediate boundary
    wr(3'd0, 32'h1);
    @(negedge clk);
    check("R2 immediate frame_start", frame_start, 1);
    rd(3'd3, 32'h1, "R2 fnum first");
    rd(3'd1, 32'h0, "R2 halted clear");
    repeat (16) @(negedge clk);
    rd(3'd3, 32'h2, "R2 fnum after one period");
    check("R5 frame_addr", frame_addr, 32'h1234_5008);

    // R3 stop
    wr(3'd0, 32'h0);
    rd(3'd1, 32'h20, "R3 halted set");
    addr_snap = frame_addr;
    count_frames(3*FC, nf);
    check("R3 no frames after stop", nf, 0);
    check("R3 frame number frozen", frame_addr, addr_snap);

    // R4 frame number write and wrap
    wr(3'd3, 32'hFFFE);
    rd(3'd3, 32'h7FE, "R4 masked write");
    wr(3'd0, 32'h1);
    rd(3'd3, 32'h7FF, "R4 top value");
    check("R5 frame_addr top index", frame_addr, 32'h1234_5FFC);
    repeat (16) @(negedge clk);
    rd(3'd3, 32'h0, "R4 wrap");
    wr(3'd3, 32'h123);
    rd(3'd3, 32'h0, "R4 write ignored while running");

    // R6/R7 completion cause held until the next boundary
    wr(3'd2, 32'h4);
    wait_frame();
    pulse(0);
    settle();
    check("R6 held within frame", irq, 0);
    rd(3'd1, 32'h0, "R6 sts not yet set");
    wait_frame(); settle();
    check("R6 posted at boundary", irq, 1);
    rd(3'd1, 32'h1, "R6 sts usbint");
    wr(3'd1, 32'h1); settle();
    check("R9 ack drops irq", irq, 0);

    // R7 separate enables: completion masked, short enabled
    wr(3'd2, 32'h8);
    wait_frame(); pulse(0);
    wait_frame(); settle();
    check("R7 completion masked", irq, 0);
    rd(3'd1, 32'h1, "R7 sts still set");
    wr(3'd1, 32'h1);
    wait_frame(); pulse(1);
    wait_frame(); settle();
    check("R7 short enabled", irq, 1);
    wr(3'd1, 32'h1); settle();
    check("R9 short cause cleared", irq, 0);

    // R8 system errors ignore enables
    wr(3'd2, 32'h0);
    pulse(3); settle();
    check("R8 hse irq", irq, 1);
    rd(3'd1, 32'h8, "R8 hse sts");
    wr(3'd1, 32'h8); settle();
    check("R9 hse cleared", irq, 0);
    pulse(4); settle();
    check("R8 perr irq", irq, 1);
    wr(3'd1, 32'h10); settle();
    check("R9 perr cleared", irq, 0);

    // R7 error enable
    pulse(2); settle();
    check("R7 err masked", irq, 0);
    rd(3'd1, 32'h2, "R7 err sts");
    wr(3'd2, 32'h1); settle();
    check("R7 err enabled", irq, 1);
    wr(3'd1, 32'h2); settle();
    check("R9 err cleared", irq, 0);

    // R10 resume
    wr(3'd0, 32'h0);
    repeat (FC + 2) @(negedge clk);
    wr(3'd2, 32'h2);
    pulse(5); settle();
    rd(3'd0, 32'h0, "R10 resume ignored cmd");
    rd(3'd1, 32'h20, "R10 resume ignored sts");
    wr(3'd0, 32'h8);
    pulse(5); settle();
    rd(3'd0, 32'h18, "R10 force resume");
    rd(3'd1, 32'h24, "R10 resume detect");
    check("R10 resume irq", irq, 1);

    // R12 bus reset
    wr(3'd0, 32'h4);
    @(negedge clk);
    check("R12 bus_reset", bus_reset, 1);

    // R11 host reset
    wr(3'd0, 32'h0);
    wr(3'd3, 32'h55);
    wr(3'd2, 32'hF);
    wr(3'd0, 32'h1);
    pulse(0);
    wr(3'd0, 32'h3);
    rd(3'd0, 32'h0, "R11 cmd");
    rd(3'd1, 32'h20, "R11 sts");
    rd(3'd2, 32'h0, "R11 ien");
    rd(3'd3, 32'h0, "R11 fnum");
    count_frames(3*FC, nf);
    check("R11 divider stopped", nf, 0);
    wr(3'd2, 32'h4);
    wr(3'd0, 32'h1);
    wait_frame(); wait_frame(); settle();
    check("R11 pending cleared", irq, 0);

    repeat (4) @(negedge clk);
    check("scoreboard drained", sbq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule